// File: doc/BRIEF.md
# Glitch-Free Synchronized Clock Stop Gate

This block takes one free-running source clock and drives a group of gated copies of it, plus one copy that is never gated. An active-low stop request, which may change at any time relative to the source clock, is passed through a chain of flops clocked by the source clock. The output of that chain is captured into an enable flop on the falling edge of the source clock. Each gated output is the AND of the source clock and that enable. Because the enable only changes while the clock is low, a stopped group always parks at logic 0. When the group restarts, its first high pulse is a full half period. Nothing in the block generates the clock itself.

The length of the synchronizer chain is a parameter, and it sets both the stop latency and the start latency in rising source edges. A chain of three suits a processor-side clock group. A chain of one suits a bus-side group. A small monitor counts how many cycles the synchronized request stays high. If a stop arrives after fewer cycles than the configured minimum enable time, the monitor raises a sticky violation flag. The flag clears only on reset.

Top module: `clk_stop_gate`

## Requirements
- R1: `clk_free` equals `clk_src` at all times, whatever `stop_req_n` does.
- R2: Every `clk_gated` bit is 0 throughout each low phase of `clk_src`.
- R3: If `stop_req_n` is sampled 0 at rising edge j, then no `clk_gated` high pulse occurs in the high phase that starts at rising edge j+SYNC_EDGES. The outputs stay at 0 for as long as the request stays low.
- R4: If `stop_req_n` is sampled 1 at rising edge j, then `clk_gated` is high for the whole high phase that starts at rising edge j+SYNC_EDGES. With the default of 3, the start latency is 3 edges; with 1, it is a single edge.
- R5: All bits of `clk_gated` carry the same value at every moment: the value is either all zeros or all ones.
- R6: While `rst_n` is 0, `clk_gated` is all zeros and `min_en_viol` is 0. After `rst_n` is released, the gated group remains stopped for the first SYNC_EDGES rising edges.
- R7: The monitor counts the rising edges at which the synchronized request is 1. If the request then falls after a high interval of fewer than MIN_EN_CYCLES such edges, `min_en_viol` becomes 1 and stays 1 until reset.
- R8: A high interval of MIN_EN_CYCLES edges or more, followed by a stop, leaves `min_en_viol` at 0.
- R9: A gated high pulse is never cut short. If `clk_gated` is high early in a high phase of `clk_src`, it is still high late in that same phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request for the gated group |
| clk_free | output | 1 | Ungated copy of the source clock |
| clk_gated | output | N_OUT | Gated clock group |
| min_en_viol | output | 1 | Sticky flag: the request was high for less than the minimum enable time |

## Verification
Two configurations are driven from the same request stream: a three-edge group with a 100-cycle minimum and a one-edge group with a 10-cycle minimum. The stream contains long running stretches, which show the free-running and steady gated behaviour. It contains one-cycle and few-cycle low pulses, which separate the stop latency from the start latency and show that short stops are neither lost nor stretched. It also contains high intervals of exactly the minimum and of one cycle less, which separate the monitor's boundary condition between "equal is allowed" and "shorter is flagged". Every output is sampled early and late in each high phase and once in each low phase, so a truncated or runt pulse is distinguished from a clean stop.

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int N_OUT         = 2,
  parameter int SYNC_EDGES    = 3,
  parameter int MIN_EN_CYCLES = 100
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             stop_req_n,
  output logic             clk_free,
  output logic [N_OUT-1:0] clk_gated,
  output logic             min_en_viol
);
  localparam int CW = $clog2(MIN_EN_CYCLES + 1);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_EN_CYCLES);

  logic [SYNC_EDGES:0] chain;
  logic                req_sync;
  logic                gate_en;
  logic [CW-1:0]       hi_cnt;

  assign chain[0] = stop_req_n;
  assign req_sync = chain[SYNC_EDGES];

  always_ff @(posedge clk_src or negedge rst_n)
    if (!rst_n) chain[SYNC_EDGES:1] <= '0;
    else        chain[SYNC_EDGES:1] <= chain[SYNC_EDGES-1:0];

  always_ff @(negedge clk_src or negedge rst_n)
    if (!rst_n) gate_en <= 1'b0;
    else        gate_en <= req_sync;

  assign clk_free = clk_src;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign clk_gated[i] = clk_src & gate_en;
  end

  always_ff @(posedge clk_src or negedge rst_n)
    if (!rst_n) begin
      hi_cnt      <= '0;
      min_en_viol <= 1'b0;
    end else begin
      if (!req_sync && hi_cnt != '0 && hi_cnt < MIN_C) min_en_viol <= 1'b1;
      if (!req_sync)            hi_cnt <= '0;
      else if (hi_cnt != MIN_C) hi_cnt <= hi_cnt + CW'(1);
    end
endmodule

module clk_stop_gate_chk #(
  parameter int N_OUT      = 2,
  parameter int SYNC_EDGES = 3
) (
  input logic             clk_src,
  input logic             rst_n,
  input logic             clk_free,
  input logic [N_OUT-1:0] clk_gated,
  input logic             gate_en,
  input logic             req_sync,
  input logic             min_en_viol
);
  a_r1_free_high: assert property (@(negedge clk_src) disable iff (!rst_n) clk_free);
  a_r1_free_low: assert property (@(posedge clk_src) disable iff (!rst_n) !clk_free);
  a_r2_low_phase: assert property (@(posedge clk_src) disable iff (!rst_n) clk_gated == '0);
  a_r5_group_same: assert property (@(negedge clk_src) disable iff (!rst_n)
    ($countones(clk_gated) == 0) || ($countones(clk_gated) == N_OUT));
  a_r3_high_follows_en: assert property (@(negedge clk_src) disable iff (!rst_n)
    clk_gated == {N_OUT{gate_en}});
  a_r4_en_from_sync: assert property (@(posedge clk_src) disable iff (!rst_n)
    gate_en == req_sync);
  a_r7_sticky: assert property (@(posedge clk_src) disable iff (!rst_n)
    $past(min_en_viol) |-> min_en_viol);
  a_r6_reset_clear: assert property (@(posedge clk_src) !rst_n |-> !min_en_viol);
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.N_OUT(N_OUT), .SYNC_EDGES(SYNC_EDGES)) u_chk (
  .clk_src(clk_src), .rst_n(rst_n), .clk_free(clk_free), .clk_gated(clk_gated),
  .gate_en(gate_en), .req_sync(req_sync), .min_en_viol(min_en_viol)
);

// File: tb/sim_clk_stop_gate.sv
module sim_clk_stop_gate;
  localparam int PERIOD = 10;
  localparam int S0 = 3, M0 = 100, N0 = 2;
  localparam int S1 = 1, M1 = 10,  N1 = 5;

  logic clk = 1'b0, rst_n = 1'b0, stop_n = 1'b1;
  logic f0, f1, v0, v1;
  logic [N0-1:0] g0;
  logic [N1-1:0] g1;

  always #(PERIOD/2) clk = ~clk;

  clk_stop_gate u0 (.clk_src(clk), .rst_n(rst_n), .stop_req_n(stop_n),
    .clk_free(f0), .clk_gated(g0), .min_en_viol(v0));
  clk_stop_gate #(.N_OUT(N1), .SYNC_EDGES(S1), .MIN_EN_CYCLES(M1)) u1 (
    .clk_src(clk), .rst_n(rst_n), .stop_req_n(stop_n),
    .clk_free(f1), .clk_gated(g1), .min_en_viol(v1));

  int vec = 0, bad = 0;
  int hist[$];
  int k = 0;
  int cnt0 = 0, cnt1 = 0;
  logic ev0 = 0, ev1 = 0, e0 = 0, e1 = 0;
  logic done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic req_at(input int idx);
    return (idx < 0) ? 1'b0 : hist[idx][0];
  endfunction

  task automatic model_edge();
    logic c;
    hist.push_back(int'(stop_n));
    c = req_at(k - S0);
    if (!c && cnt0 > 0 && cnt0 < M0) ev0 = 1;
    cnt0 = c ? ((cnt0 < M0) ? cnt0 + 1 : cnt0) : 0;
    e0 = c;
    c = req_at(k - S1);
    if (!c && cnt1 > 0 && cnt1 < M1) ev1 = 1;
    cnt1 = c ? ((cnt1 < M1) ? cnt1 + 1 : cnt1) : 0;
    e1 = c;
    k++;
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    #2;
    chk(e0 ? "R4 u0" : "R3 u0", 32'(g0), e0 ? 32'(2**N0-1) : 0);
    chk(e1 ? "R4 u1" : "R3 u1", 32'(g1), e1 ? 32'(2**N1-1) : 0);
    chk("R1 high", {30'd0, f0, f1}, 32'd3);
    chk("R5 u1", 32'(($countones(g1) == 0) || ($countones(g1) == N1)), 1);
    chk(ev0 ? "R7 u0" : "R8 u0", 32'(v0), 32'(ev0));
    chk(ev1 ? "R7 u1" : "R8 u1", 32'(v1), 32'(ev1));
    #2;
    chk("R9 u0", 32'(g0), e0 ? 32'(2**N0-1) : 0);
    chk("R9 u1", 32'(g1), e1 ? 32'(2**N1-1) : 0);
    @(negedge clk);
    #1;
    chk("R2", {g0, g1}, 0);
    chk("R1 low", {30'd0, f0, f1}, 0);
  endtask

  task automatic run(input logic lvl, input int n);
    stop_n = lvl;
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R6 gated", {g0, g1}, 0);
    chk("R6 viol", {30'd0, v0, v1}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    run(1, 150);
    run(0, 20);
    run(1, 100);
    run(0, 1);
    run(1, 99);
    run(0, 3);
    run(1, 10);
    run(0, 3);
    run(1, 9);
    run(0, 2);
    run(1, 60);
    chk("R7 u0 final", 32'(v0), 1);
    chk("R7 u1 final", 32'(v1), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule